// File: doc/BRIEF.md
# Video Register Command Decoder

This block sits between a byte-oriented command stream and the display timing logic. It takes bytes over a valid/ready interface and finds register-write commands in the stream. Each command is a fixed prefix byte, an opcode byte, a register address and a data byte. The decoder writes the data byte into an image of an 8-bit-addressed video register file. The timing generator reads a live copy of the settings: timing words, pixel clock, two framebuffer base addresses, colour depth and sync state.

Host software brackets a mode change with a lock write and an unlock write to a control address. Every accepted write goes into a shadow image first. The live image is loaded from the shadow in one clock, on the unlock that ends a locked period, so the timing logic never sees a half-programmed mode. A malformed command makes the decoder drop back to searching for the prefix without touching any register. A power-down guard stops sync from being re-enabled until the timing has been reprogrammed.

Top module: `vidcmd_decoder`

## Requirements
- R1: After reset the outputs are: `locked` 0, `commit` 0, `sync_mode` 2 (power-down), `depth24` 0, both base addresses 0 and all timing words 0. The stored sync byte resets to 0x07 and the power-down guard of R11 resets to armed.
- R2: A write is the byte sequence 0xAF, 0x20, address, data. `in_ready` is always high. A written value goes into the shadow image only and does not appear on any live output before a commit.
- R3: If the byte after 0xAF is anything other than 0x20, including another 0xAF, that byte is discarded and the decoder goes back to searching for 0xAF. Bytes seen while searching are ignored, and no register changes.
- R4: Writing 0x00 to address 0xFF sets `locked`. Writing 0xFF to address 0xFF while locked clears `locked` and raises `commit` for exactly one clock. The live image is loaded from the shadow on that same edge, which is one clock after the data byte of the unlock write is accepted. The live image changes on no other edge.
- R5: An unlock write while not locked produces no commit. A write to 0xFF with any data other than 0x00 or 0xFF has no effect. Writes made while unlocked stay staged and go live at the next commit.
- R6: Timing word k, for k = 0 to 11, sits at addresses 0x01+2k (high byte) and 0x02+2k (low byte). It appears on `timing_words[16k+15:16k]`.
- R7: The pixel clock word, in 5 kHz units, takes its low byte from 0x1B and its high byte from 0x1C.
- R8: The 24-bit 16 bpp base is at 0x20, 0x21 and 0x22, most significant byte first. The 24-bit 8 bpp base is at 0x26, 0x27 and 0x28 in the same order.
- R9: `depth24` is bit 0 of register 0x00: 0 selects 16 bpp and 1 selects 24 bpp.
- R10: `sync_mode` decodes register 0x1F as follows: 0x00 gives 0 (syncs active), 0x01 gives 1 (blanked, powered), 0x07 gives 2 (power-down), and any other value gives 3 (reserved).
- R11: Writing 0x07 to 0x1F arms the power-down guard. While the guard is armed, a write of any other value to 0x1F is dropped. A write to any timing address (0x01 to 0x18, 0x1B, 0x1C) disarms the guard.
- R12: Writes to addresses 0x40 to 0xFE change nothing, and none of them aliases onto a lower address. A byte offered while `in_valid` is low is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Decoder accepts a byte (always high) |
| locked | output | 1 | Register lock is held |
| commit | output | 1 | One-clock pulse when the shadow is loaded into the live image |
| depth24 | output | 1 | Live colour depth, 1 = 24 bpp |
| sync_mode | output | 2 | Live decoded sync state |
| timing_words | output | 192 | Twelve live 16-bit timing words |
| pixel_clk | output | 16 | Live pixel clock in 5 kHz units |
| base16 | output | 24 | Live 16 bpp framebuffer base |
| base8 | output | 24 | Live 8 bpp framebuffer base |

## Verification
The data byte of a write is accepted on some edge E. The decoder turns it into an internal write strobe that is valid for the following cycle. The shadow, `locked` and, for an unlock, `commit` together with every live output all update on edge E+1. The bench drives each byte one time unit after a rising edge and samples one time unit after the edge of interest. It checks `commit` low just after E, high after E+1 and low again after E+2. Every staged value is confirmed absent before its commit and present right after it.

// File: rtl/vidcmd_pkg.sv
package vidcmd_pkg;

  localparam logic [7:0] CMD_PREFIX   = 8'hAF;
  localparam logic [7:0] OP_REG_WRITE = 8'h20;

  localparam logic [7:0] ADDR_LOCKCTL = 8'hFF;
  localparam logic [7:0] LOCK_CODE    = 8'h00;
  localparam logic [7:0] UNLOCK_CODE  = 8'hFF;

  localparam logic [7:0] ADDR_DEPTH   = 8'h00;
  localparam logic [7:0] ADDR_TIMING0 = 8'h01;
  localparam logic [7:0] ADDR_PCLK    = 8'h1B;
  localparam logic [7:0] ADDR_SYNC    = 8'h1F;
  localparam logic [7:0] ADDR_BASE16  = 8'h20;
  localparam logic [7:0] ADDR_BASE8   = 8'h26;

  localparam logic [7:0] SYNC_ON_CODE    = 8'h00;
  localparam logic [7:0] SYNC_BLANK_CODE = 8'h01;
  localparam logic [7:0] SYNC_OFF_CODE   = 8'h07;

  typedef enum logic [1:0] {
    SYNC_ACTIVE    = 2'd0,
    SYNC_BLANKED   = 2'd1,
    SYNC_POWERDOWN = 2'd2,
    SYNC_RESERVED  = 2'd3
  } sync_mode_e;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_OPCODE = 2'd1,
    ST_ADDR   = 2'd2,
    ST_DATA   = 2'd3
  } frame_st_e;

  typedef struct packed {
    logic       vld;
    logic [7:0] addr;
    logic [7:0] data;
  } reg_wr_t;

endpackage

// File: rtl/vidcmd_framer.sv
module vidcmd_framer
  import vidcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output reg_wr_t    wr_o
);

  frame_st_e  state_q, state_d;
  logic [7:0] addr_q, addr_d;
  reg_wr_t    wr_q, wr_d;
  logic       fire;

  assign in_ready = 1'b1;
  assign fire     = in_valid & in_ready;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    wr_d      = wr_q;
    wr_d.vld  = 1'b0;
    if (fire) begin
      case (state_q)
        ST_HUNT: begin
          if (in_data == CMD_PREFIX) state_d = ST_OPCODE;
        end
        ST_OPCODE: begin
          state_d = (in_data == OP_REG_WRITE) ? ST_ADDR : ST_HUNT;
        end
        ST_ADDR: begin
          addr_d  = in_data;
          state_d = ST_DATA;
        end
        ST_DATA: begin
          wr_d.vld  = 1'b1;
          wr_d.addr = addr_q;
          wr_d.data = in_data;
          state_d   = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      addr_q  <= '0;
      wr_q    <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      wr_q    <= wr_d;
    end
  end

  assign wr_o = wr_q;

  // R2: a write strobe follows an accepted byte
  p_wr_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q.vld |-> $past(in_valid));

  // R2: four bytes per command, so strobes never touch
  p_wr_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q.vld |=> !wr_q.vld);

  // R3: a rejected opcode produces no write on the next cycle
  p_bad_opcode_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPCODE && in_valid) |=> !wr_q.vld);

endmodule

// File: rtl/vidcmd_regfile.sv
module vidcmd_regfile
  import vidcmd_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_TIMING = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  reg_wr_t               wr_i,
  output logic                  locked_o,
  output logic                  commit_o,
  output logic [DEPTH-1:0][7:0] live_o
);

  localparam int         SYNC_IDX  = int'(ADDR_SYNC);
  localparam logic [8:0] DEPTH9    = 9'(DEPTH);
  localparam logic [7:0] TIM_LIMIT = 8'(int'(ADDR_TIMING0) + 2 * NUM_TIMING);

  function automatic logic [DEPTH-1:0][7:0] reset_image();
    logic [DEPTH-1:0][7:0] img;
    img           = '0;
    img[SYNC_IDX] = SYNC_OFF_CODE;
    return img;
  endfunction

  localparam logic [DEPTH-1:0][7:0] RST_IMG = reset_image();

  function automatic logic is_timing(input logic [7:0] a);
    return ((a >= ADDR_TIMING0) && (a < TIM_LIMIT)) ||
           (a == ADDR_PCLK) || (a == ADDR_PCLK + 8'd1);
  endfunction

  logic [DEPTH-1:0][7:0] shadow_q, shadow_d;
  logic [DEPTH-1:0][7:0] live_q, live_d;
  logic locked_q, locked_d;
  logic commit_q, commit_d;
  logic guard_q, guard_d;

  logic in_range, ctl_hit, lock_cmd, unlock_cmd, sync_hit, sync_drop, shadow_we;

  assign in_range   = wr_i.vld && ({1'b0, wr_i.addr} < DEPTH9);
  assign ctl_hit    = wr_i.vld && (wr_i.addr == ADDR_LOCKCTL);
  assign lock_cmd   = ctl_hit && (wr_i.data == LOCK_CODE);
  assign unlock_cmd = ctl_hit && (wr_i.data == UNLOCK_CODE);
  assign sync_hit   = in_range && (wr_i.addr == ADDR_SYNC);
  assign sync_drop  = sync_hit && guard_q && (wr_i.data != SYNC_OFF_CODE);
  assign shadow_we  = in_range && !sync_drop;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_shadow
      assign shadow_d[g] = (shadow_we && (wr_i.addr == 8'(g))) ? wr_i.data : shadow_q[g];
    end
  endgenerate

  always_comb begin
    locked_d = locked_q;
    commit_d = 1'b0;
    guard_d  = guard_q;
    if (lock_cmd) begin
      locked_d = 1'b1;
    end else if (unlock_cmd && locked_q) begin
      locked_d = 1'b0;
      commit_d = 1'b1;
    end
    if (sync_hit && (wr_i.data == SYNC_OFF_CODE)) begin
      guard_d = 1'b1;
    end else if (in_range && is_timing(wr_i.addr)) begin
      guard_d = 1'b0;
    end
    live_d = commit_d ? shadow_q : live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_IMG;
      live_q   <= RST_IMG;
      locked_q <= 1'b0;
      commit_q <= 1'b0;
      guard_q  <= 1'b1;
    end else begin
      shadow_q <= shadow_d;
      live_q   <= live_d;
      locked_q <= locked_d;
      commit_q <= commit_d;
      guard_q  <= guard_d;
    end
  end

  assign locked_o = locked_q;
  assign commit_o = commit_q;
  assign live_o   = live_q;

  // R4: the commit pulse lasts one clock
  p_commit_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

  // R4: the commit is caused by an unlock strobe from the framer
  p_commit_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(wr_i.vld && wr_i.addr == ADDR_LOCKCTL && wr_i.data == UNLOCK_CODE));

  // R4: the live image moves only together with the commit pulse
  p_live_only_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_q) |-> commit_q);

  // R5: no commit can follow a cycle that was not locked
  p_no_commit_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |=> !commit_q);

  // R11: an armed guard keeps the staged sync byte unchanged
  p_pd_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_q && wr_i.vld && wr_i.addr == ADDR_SYNC && wr_i.data != SYNC_OFF_CODE)
      |=> $stable(shadow_q[SYNC_IDX]));

endmodule

// File: rtl/vidcmd_outmap.sv
module vidcmd_outmap
  import vidcmd_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_TIMING = 12
) (
  input  logic [DEPTH-1:0][7:0]     live_i,
  output logic                      depth24_o,
  output logic [1:0]                sync_mode_o,
  output logic [NUM_TIMING*16-1:0]  timing_o,
  output logic [15:0]               pclk_o,
  output logic [23:0]               base16_o,
  output logic [23:0]               base8_o
);

  localparam int DEPTH_IDX = int'(ADDR_DEPTH);
  localparam int SYNC_IDX  = int'(ADDR_SYNC);
  localparam int PCLK_IDX  = int'(ADDR_PCLK);
  localparam int B16_IDX   = int'(ADDR_BASE16);
  localparam int B8_IDX    = int'(ADDR_BASE8);
  localparam int TIM_IDX   = int'(ADDR_TIMING0);

  sync_mode_e mode;

  generate
    for (genvar k = 0; k < NUM_TIMING; k++) begin : g_timing
      localparam int HI = TIM_IDX + 2 * k;
      assign timing_o[16*k +: 16] = {live_i[HI], live_i[HI+1]};
    end
    for (genvar b = 0; b < 3; b++) begin : g_base
      assign base16_o[8*(2-b) +: 8] = live_i[B16_IDX + b];
      assign base8_o[8*(2-b) +: 8]  = live_i[B8_IDX + b];
    end
  endgenerate

  assign pclk_o    = {live_i[PCLK_IDX+1], live_i[PCLK_IDX]};
  assign depth24_o = live_i[DEPTH_IDX][0];

  always_comb begin
    case (live_i[SYNC_IDX])
      SYNC_ON_CODE:    mode = SYNC_ACTIVE;
      SYNC_BLANK_CODE: mode = SYNC_BLANKED;
      SYNC_OFF_CODE:   mode = SYNC_POWERDOWN;
      default:         mode = SYNC_RESERVED;
    endcase
  end

  assign sync_mode_o = mode;

  logic unused_live;
  assign unused_live = ^live_i;

endmodule

// File: rtl/vidcmd_decoder.sv
module vidcmd_decoder
  import vidcmd_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_TIMING = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  output logic                     in_ready,
  output logic                     locked,
  output logic                     commit,
  output logic                     depth24,
  output logic [1:0]               sync_mode,
  output logic [NUM_TIMING*16-1:0] timing_words,
  output logic [15:0]              pixel_clk,
  output logic [23:0]              base16,
  output logic [23:0]              base8
);

  reg_wr_t               wr;
  logic [DEPTH-1:0][7:0] live;

  vidcmd_framer u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .wr_o     (wr)
  );

  vidcmd_regfile #(
    .DEPTH      (DEPTH),
    .NUM_TIMING (NUM_TIMING)
  ) u_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr),
    .locked_o (locked),
    .commit_o (commit),
    .live_o   (live)
  );

  vidcmd_outmap #(
    .DEPTH      (DEPTH),
    .NUM_TIMING (NUM_TIMING)
  ) u_outmap (
    .live_i      (live),
    .depth24_o   (depth24),
    .sync_mode_o (sync_mode),
    .timing_o    (timing_words),
    .pclk_o      (pclk_o_w),
    .base16_o    (base16),
    .base8_o     (base8)
  );

  logic [15:0] pclk_o_w;
  assign pixel_clk = pclk_o_w;

endmodule

// File: tb/vidcmd_decoder_test.sv
module vidcmd_decoder_test;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   in_data;
  logic         in_ready;
  logic         locked;
  logic         commit;
  logic         depth24;
  logic [1:0]   sync_mode;
  logic [191:0] timing_words;
  logic [15:0]  pixel_clk;
  logic [23:0]  base16;
  logic [23:0]  base8;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 0;

  vidcmd_decoder uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .locked       (locked),
    .commit       (commit),
    .depth24      (depth24),
    .sync_mode    (sync_mode),
    .timing_words (timing_words),
    .pixel_clk    (pixel_clk),
    .base16       (base16),
    .base8        (base8)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drives one byte, returns one time unit after the accepting edge
  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send_byte(8'hAF);
    send_byte(8'h20);
    send_byte(a);
    send_byte(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_lock();
    wr(8'hFF, 8'h00);
    idle(1);
  endtask

  // unlock, check commit timing, return one unit after the commit edge
  task automatic do_commit(input string req);
    wr(8'hFF, 8'hFF);
    chk(req, "commit before edge", 32'(commit), 32'd0);
    idle(1);
    chk(req, "commit pulse", 32'(commit), 32'd1);
    chk(req, "locked after unlock", 32'(locked), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "locked", 32'(locked), 32'd0);
    chk("R1", "commit", 32'(commit), 32'd0);
    chk("R1", "sync_mode", 32'(sync_mode), 32'd2);
    chk("R1", "depth24", 32'(depth24), 32'd0);
    chk("R1", "base16", 32'(base16), 32'd0);
    chk("R1", "base8", 32'(base8), 32'd0);
    chk("R1", "timing word0", 32'(timing_words[15:0]), 32'd0);
    chk("R2", "in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_staged();
    do_lock();
    chk("R4", "locked after lock", 32'(locked), 32'd1);
    wr(8'h00, 8'h01);
    idle(1);
    chk("R2", "depth staged only", 32'(depth24), 32'd0);
    do_commit("R4");
    chk("R9", "depth24 after commit", 32'(depth24), 32'd1);
    chk("R1", "sync still powered down", 32'(sync_mode), 32'd2);
    idle(1);
    chk("R4", "commit one clock", 32'(commit), 32'd0);
  endtask

  task automatic t_timing();
    do_lock();
    wr(8'h01, 8'h12); wr(8'h02, 8'h34);
    wr(8'h0B, 8'h9A); wr(8'h0C, 8'hBC);
    wr(8'h17, 8'hAB); wr(8'h18, 8'hCD);
    wr(8'h1B, 8'h78); wr(8'h1C, 8'h56);
    idle(1);
    chk("R2", "timing staged only", 32'(timing_words[15:0]), 32'd0);
    do_commit("R4");
    chk("R6", "timing word0", 32'(timing_words[15:0]), 32'h1234);
    chk("R6", "timing word5", 32'(timing_words[95:80]), 32'h9ABC);
    chk("R6", "timing word11", 32'(timing_words[191:176]), 32'hABCD);
    chk("R7", "pixel clock", 32'(pixel_clk), 32'h5678);
  endtask

  task automatic t_bases();
    do_lock();
    wr(8'h20, 8'h01); wr(8'h21, 8'h02); wr(8'h22, 8'h03);
    wr(8'h26, 8'hA0); wr(8'h27, 8'hB0); wr(8'h28, 8'hC0);
    do_commit("R4");
    chk("R8", "base16", 32'(base16), 32'h010203);
    chk("R8", "base8", 32'(base8), 32'hA0B0C0);
  endtask

  task automatic t_sync();
    do_lock(); wr(8'h1F, 8'h01); do_commit("R4");
    chk("R10", "blank code", 32'(sync_mode), 32'd1);
    do_lock(); wr(8'h1F, 8'h07); do_commit("R4");
    chk("R10", "power-down code", 32'(sync_mode), 32'd2);
    do_lock(); wr(8'h1F, 8'h00); do_commit("R4");
    chk("R11", "enable dropped while guarded", 32'(sync_mode), 32'd2);
    do_lock(); wr(8'h09, 8'h00); wr(8'h1F, 8'h00); do_commit("R4");
    chk("R11", "enable after timing rewrite", 32'(sync_mode), 32'd0);
    do_lock(); wr(8'h1F, 8'h05); do_commit("R4");
    chk("R10", "reserved code", 32'(sync_mode), 32'd3);
    do_lock(); wr(8'h1F, 8'h00); do_commit("R4");
    chk("R10", "active code", 32'(sync_mode), 32'd0);
  endtask

  task automatic t_resync();
    send_byte(8'h00); send_byte(8'h20);
    send_byte(8'hAF); send_byte(8'h55); send_byte(8'h20);
    send_byte(8'h00); send_byte(8'h00);
    send_byte(8'hAF); send_byte(8'hAF); send_byte(8'h20);
    send_byte(8'h00); send_byte(8'h00);
    idle(1);
    chk("R3", "no lock from bad frames", 32'(locked), 32'd0);
    in_data = 8'hAF;
    idle(2);
    send_byte(8'h20); send_byte(8'hFF); send_byte(8'h00);
    idle(1);
    chk("R12", "byte without valid not consumed", 32'(locked), 32'd0);
    do_lock(); do_commit("R4");
    chk("R3", "depth untouched", 32'(depth24), 32'd1);
    chk("R3", "sync untouched", 32'(sync_mode), 32'd0);
    do_lock(); wr(8'h00, 8'h00); do_commit("R4");
    chk("R3", "framing recovered", 32'(depth24), 32'd0);
  endtask

  task automatic t_ctl();
    wr(8'hFF, 8'hFF);
    idle(1);
    chk("R5", "no commit when unlocked", 32'(commit), 32'd0);
    idle(1);
    chk("R5", "still no commit", 32'(commit), 32'd0);
    wr(8'h00, 8'h01);
    idle(2);
    chk("R5", "unlocked write stays staged", 32'(depth24), 32'd0);
    do_lock();
    wr(8'hFF, 8'h42);
    idle(2);
    chk("R5", "other control data ignored", 32'(locked), 32'd1);
    chk("R5", "no commit from other data", 32'(commit), 32'd0);
    do_commit("R5");
    chk("R5", "staged write went live", 32'(depth24), 32'd1);
  endtask

  task automatic t_range();
    do_lock();
    wr(8'h40, 8'h00);
    wr(8'h5F, 8'h07);
    wr(8'h9F, 8'h05);
    wr(8'h60, 8'h55);
    do_commit("R4");
    chk("R12", "no alias onto depth", 32'(depth24), 32'd1);
    chk("R12", "no alias onto sync", 32'(sync_mode), 32'd0);
    chk("R12", "no alias onto timing", 32'(timing_words[15:0]), 32'h1234);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_staged();
    t_timing();
    t_bases();
    t_sync();
    t_resync();
    t_ctl();
    t_range();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule